// File: doc/BRIEF.md
# Quadrature Chroma Modulator and Composite Mixer

This block turns one colour sample per dot clock into a single 9-bit analogue-video code. Each sample carries a luma value Y, two signed colour-difference values I and Q, three 8-bit pedestal offsets, two sync bits and an output-mode selector. The (I,Q) vector is rotated by a subcarrier phase that moves one sixteenth of a turn on every dot-enable. The rotated Q term is the chroma signal. The block can then produce a composite code, an s-video luma code or an s-video chroma code. Sync is not carried on a separate channel. It is inserted as fixed pedestal levels.

The rotation is an unrolled, fully pipelined CORDIC, so a new sample is accepted on every dot-enable. The CORDIC gain is not corrected in hardware. Whoever supplies I and Q is expected to have scaled them by about 0.608 beforehand. A start input restarts the subcarrier at phase zero, so a line or field can be locked to a known burst phase. All sums wrap modulo 512.

Top module: `chroma_quad_mixer`

## Requirements
- R1: The sample taken on a dot-enable with `start` high uses phase 0. Every later dot-enable uses the previous phase plus one, modulo 16, so the phase returns to 0 after 16 steps.
- R2: The chroma term equals 1.6468 × (I·sin θ + Q·cos θ) within ±2 LSB. Here θ is phase × 22.5°, and I and Q are read as 9-bit two's-complement values.
- R3: In composite mode (`mode` = 00), the output is chosen by the sync bits:
  - `sync` = 00 gives 2·YO + Y + chroma.
  - `sync` = 01 gives 2·IO + chroma.
  - Any `sync` value with bit 1 set gives chroma alone.
- R4: In s-video luma mode (`mode` = 01), the output is chosen by the sync bits:
  - `sync` = 00 gives 2·YO + Y.
  - `sync` = 01 gives 2·IO.
  - Any `sync` value with bit 1 set gives 0.
- R5: In s-video chroma mode (`mode` = 10 or 11), the output is 2·QO + chroma, whatever the sync bits are.
- R6: Every output sum wraps modulo 512 and is presented as a 9-bit unsigned code.
- R7: `dac_out` changes only on a clock edge where `dot_en` is high. The result for a sample appears on the (N_STAGES+2)-th dot-enable edge, counting the edge that captures the sample.
- R8: While reset is asserted, and until the pipeline has filled, `dac_out` is 0 and the phase is 0.
- R9: When I and Q are both 0, chroma is exactly 0 at all 16 phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot-clock enable; one sample is taken per high cycle |
| start | input | 1 | Forces the current sample to phase 0 |
| mode | input | 2 | 00 composite, 01 s-video luma, 1x s-video chroma |
| sync | input | 2 | 00 pixel, 01 sync high, 1x sync low |
| y_in | input | 9 | Luma component |
| i_in | input | 9 | I component, two's complement, pre-scaled |
| q_in | input | 9 | Q component, two's complement, pre-scaled |
| y_ofs | input | 8 | Luma pedestal offset (YO) |
| i_ofs | input | 8 | Sync-high pedestal offset (IO) |
| q_ofs | input | 8 | Chroma pedestal offset (QO) |
| dac_out | output | 9 | Output code, modulo 512 |

## Verification
The assertions assume the following about the inputs:
- Reset is applied before the first dot-enable.
- `dot_en` and `start` are known values at every edge.
- `start` matters only in a cycle where `dot_en` is high.
- The mode and sync fields of a sample travel unchanged alongside its rotated vector.

The stimulus changes every input on the falling clock edge only. It raises `start` at the beginning and again in mid-stream. It runs both unbroken and gapped dot-enable patterns, holds I and Q at zero for more than 16 consecutive phases, and includes pedestal and luma values large enough to force the modulo-512 wrap.

// File: rtl/cqm_pkg.sv
`timescale 1ns/1ps
package cqm_pkg;

   localparam int CODE_W = 9;   // sample and output code width
   localparam int OFS_W  = 8;   // pedestal offset width
   localparam int ANG_W  = 16;  // one full turn equals 2**ANG_W angle units

   typedef enum logic [1:0] {
      MODE_COMPOSITE  = 2'b00,
      MODE_LUMA       = 2'b01,
      MODE_CHROMA     = 2'b10,
      MODE_CHROMA_ALT = 2'b11
   } out_mode_e;

   typedef struct packed {
      logic [CODE_W-1:0] luma;
      logic [OFS_W-1:0]  ofs_y;
      logic [OFS_W-1:0]  ofs_i;
      logic [OFS_W-1:0]  ofs_q;
      logic [1:0]        sync;
      out_mode_e         mode;
   } side_t;

   // arctan(2^-idx) expressed in units of 1/65536 turn
   function automatic logic [ANG_W-1:0] atan_step(input int idx);
      case (idx)
         0:  return 16'd8192;
         1:  return 16'd4836;
         2:  return 16'd2555;
         3:  return 16'd1297;
         4:  return 16'd651;
         5:  return 16'd326;
         6:  return 16'd163;
         7:  return 16'd81;
         8:  return 16'd41;
         9:  return 16'd20;
         10: return 16'd10;
         11: return 16'd5;
         12: return 16'd3;
         13: return 16'd1;
         14: return 16'd1;
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/cqm_phase.sv
`timescale 1ns/1ps
module cqm_phase #(
   parameter int PH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dot_en,
   input  logic            start,
   output logic [PH_W-1:0] phase
);

   logic [PH_W-1:0] ph_q;

   assign phase = start ? '0 : ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ph_q <= '0;
      else if (dot_en) ph_q <= phase + 1'b1;
   end

   // R1: free-running advance by one step per dot-enable
   p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && !start) |=> (ph_q == PH_W'($past(ph_q) + 1'b1)));

   // R1: start restarts the sequence so the following sample uses step 1
   p_phase_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && start) |=> (ph_q == PH_W'(1)));

   // R8: phase holds between dot-enables
   p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dot_en |=> $stable(ph_q));

endmodule

// File: rtl/cqm_cordic.sv
`timescale 1ns/1ps
module cqm_cordic import cqm_pkg::*; #(
   parameter int IN_W     = 9,
   parameter int FRAC     = 6,
   parameter int N_STAGES = 12,
   parameter int PH_W     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic signed [IN_W-1:0] i_in,
   input  logic signed [IN_W-1:0] q_in,
   input  logic [PH_W-1:0]        phase,
   output logic signed [IN_W-1:0] chroma
);

   localparam int W  = IN_W + 3 + FRAC;   // headroom for gain 1.65 times root two
   localparam int ZW = ANG_W + 1;
   localparam logic signed [W-1:0] RND = W'(1) <<< (FRAC - 1);

   if (N_STAGES < 8 || N_STAGES > 16) begin : g_bad_stages
      $error("cqm_cordic: N_STAGES must lie in 8..16");
   end
   if (FRAC < 1) begin : g_bad_frac
      $error("cqm_cordic: FRAC must be at least 1");
   end
   if (PH_W < 3 || PH_W > ANG_W - 2) begin : g_bad_phase
      $error("cqm_cordic: PH_W out of range");
   end

   logic signed [W-1:0]  i_ext, q_ext, x_pre, y_pre;
   logic signed [ZW-1:0] z_pre;

   assign i_ext = W'(i_in) <<< FRAC;
   assign q_ext = W'(q_in) <<< FRAC;

   // quarter-turn pre-rotation leaves a residual angle below 90 degrees
   always_comb begin
      unique case (phase[PH_W-1 -: 2])
         2'd0:    begin x_pre = i_ext;  y_pre = q_ext;  end
         2'd1:    begin x_pre = -q_ext; y_pre = i_ext;  end
         2'd2:    begin x_pre = -i_ext; y_pre = -q_ext; end
         default: begin x_pre = q_ext;  y_pre = -i_ext; end
      endcase
   end

   assign z_pre = ZW'(phase[PH_W-3:0]) << (ANG_W - PH_W);

   logic signed [W-1:0]  x_q [N_STAGES];
   logic signed [W-1:0]  y_q [N_STAGES+1];
   logic signed [ZW-1:0] z_q [N_STAGES];
   logic signed [W-1:0]  x_n [N_STAGES-1];
   logic signed [W-1:0]  y_n [N_STAGES];
   logic signed [ZW-1:0] z_n [N_STAGES-1];

   for (genvar k = 0; k < N_STAGES; k++) begin : g_iter
      logic ccw;
      assign ccw    = ~z_q[k][ZW-1];
      assign y_n[k] = ccw ? (y_q[k] + (x_q[k] >>> k)) : (y_q[k] - (x_q[k] >>> k));
      if (k < N_STAGES - 1) begin : g_carry
         assign x_n[k] = ccw ? (x_q[k] - (y_q[k] >>> k)) : (x_q[k] + (y_q[k] >>> k));
         assign z_n[k] = ccw ? (z_q[k] - ZW'(atan_step(k))) : (z_q[k] + ZW'(atan_step(k)));
      end

      // R9: a null vector stays null through every micro-rotation
      p_zero_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (en && x_q[k] == '0 && y_q[k] == '0) |=> (y_q[k+1] == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_STAGES; k++) begin
            x_q[k] <= '0;
            z_q[k] <= '0;
         end
         for (int k = 0; k <= N_STAGES; k++) y_q[k] <= '0;
      end else if (en) begin
         x_q[0] <= x_pre;
         y_q[0] <= y_pre;
         z_q[0] <= z_pre;
         for (int k = 0; k < N_STAGES - 1; k++) begin
            x_q[k+1] <= x_n[k];
            z_q[k+1] <= z_n[k];
         end
         for (int k = 0; k < N_STAGES; k++) y_q[k+1] <= y_n[k];
      end
   end

   assign chroma = IN_W'((y_q[N_STAGES] + RND) >>> FRAC);

endmodule

// File: rtl/cqm_mixer.sv
`timescale 1ns/1ps
module cqm_mixer import cqm_pkg::*; (
   input  side_t             side,
   input  logic [CODE_W-1:0] chroma,
   output logic [CODE_W-1:0] code
);

   logic [CODE_W-1:0] luma_px, sync_hi, chroma_ped;

   assign luma_px    = {side.ofs_y, 1'b0} + side.luma;
   assign sync_hi    = {side.ofs_i, 1'b0};
   assign chroma_ped = {side.ofs_q, 1'b0} + chroma;

   always_comb begin
      unique case (side.mode)
         MODE_COMPOSITE: begin
            if (side.sync[1])      code = chroma;
            else if (side.sync[0]) code = sync_hi + chroma;
            else                   code = luma_px + chroma;
         end
         MODE_LUMA: begin
            if (side.sync[1])      code = '0;
            else if (side.sync[0]) code = sync_hi;
            else                   code = luma_px;
         end
         default:                  code = chroma_ped;
      endcase
   end

endmodule

// File: rtl/chroma_quad_mixer.sv
`timescale 1ns/1ps
module chroma_quad_mixer import cqm_pkg::*; #(
   parameter int N_STAGES  = 12,
   parameter int FRAC_BITS = 6,
   parameter int PHASE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dot_en,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [1:0]        sync,
   input  logic [CODE_W-1:0] y_in,
   input  logic [CODE_W-1:0] i_in,
   input  logic [CODE_W-1:0] q_in,
   input  logic [OFS_W-1:0]  y_ofs,
   input  logic [OFS_W-1:0]  i_ofs,
   input  logic [OFS_W-1:0]  q_ofs,
   output logic [CODE_W-1:0] dac_out
);

   localparam int SIDE_D = N_STAGES + 1;   // matches the rotator depth

   logic [PHASE_W-1:0]       phase;
   logic signed [CODE_W-1:0] chroma_s;
   logic [CODE_W-1:0]        mix_code;
   side_t                    side_in;
   side_t                    side_q [SIDE_D];

   cqm_phase #(.PH_W(PHASE_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .dot_en (dot_en),
      .start  (start),
      .phase  (phase)
   );

   cqm_cordic #(
      .IN_W     (CODE_W),
      .FRAC     (FRAC_BITS),
      .N_STAGES (N_STAGES),
      .PH_W     (PHASE_W)
   ) u_rot (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (dot_en),
      .i_in   (i_in),
      .q_in   (q_in),
      .phase  (phase),
      .chroma (chroma_s)
   );

   assign side_in = '{luma: y_in, ofs_y: y_ofs, ofs_i: i_ofs, ofs_q: q_ofs,
                      sync: sync, mode: out_mode_e'(mode)};

   cqm_mixer u_mix (
      .side   (side_q[SIDE_D-1]),
      .chroma (chroma_s),
      .code   (mix_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SIDE_D; k++) side_q[k] <= '0;
         dac_out <= '0;
      end else if (dot_en) begin
         side_q[0] <= side_in;
         for (int k = 1; k < SIDE_D; k++) side_q[k] <= side_q[k-1];
         dac_out <= mix_code;
      end
   end

   // R7: output register moves only with the dot clock
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dot_en |=> $stable(dac_out));

   // R4: luma sync-low level is zero
   p_luma_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && side_q[SIDE_D-1].mode == MODE_LUMA && side_q[SIDE_D-1].sync[1])
      |=> (dac_out == '0));

   // R3: composite sync-low carries only the rotated chroma term
   p_comp_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && side_q[SIDE_D-1].mode == MODE_COMPOSITE && side_q[SIDE_D-1].sync[1])
      |=> (dac_out == $unsigned($past(chroma_s))));

   // R5: chroma mode with null chroma rests on the doubled chroma pedestal
   p_chroma_ped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && side_q[SIDE_D-1].mode[1] && chroma_s == '0)
      |=> (dac_out == {$past(side_q[SIDE_D-1].ofs_q), 1'b0}));

endmodule

// File: tb/chroma_quad_mixer_tb_top.sv
`timescale 1ns/1ps
module chroma_quad_mixer_tb_top;

   localparam int  NST  = 12;
   localparam int  LAT  = NST + 1;   // dot-enables between capture and the update showing it
   localparam real PI   = 3.14159265358979;
   localparam real GAIN = 1.6467602;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       dot_en = 1'b0;
   logic       start = 1'b0;
   logic [1:0] mode = '0;
   logic [1:0] sync = '0;
   logic [8:0] y_in = '0, i_in = '0, q_in = '0;
   logic [7:0] y_ofs = '0, i_ofs = '0, q_ofs = '0;
   logic [8:0] dac_out;

   int    compared = 0;
   int    mismatched = 0;
   int    ph_m = 0;
   int    exp_q[$];
   int    tol_q[$];
   string tag_q[$];
   int    cur_exp = 0;
   int    cur_tol = 0;
   string cur_tag = "R8 reset/fill";
   bit    done = 1'b0;

   always #2 clk = ~clk;

   chroma_quad_mixer #(.N_STAGES(NST), .FRAC_BITS(6), .PHASE_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .start(start),
      .mode(mode), .sync(sync), .y_in(y_in), .i_in(i_in), .q_in(q_in),
      .y_ofs(y_ofs), .i_ofs(i_ofs), .q_ofs(q_ofs), .dac_out(dac_out)
   );

   function automatic int wrap512(input int v);
      return ((v % 512) + 512) % 512;
   endfunction

   // behavioural model of one sample, using the values present at the edge
   function automatic void model(input int ph, output int val, output int tol, output string tag);
      int  iv, qv, c, raw;
      bit  uses_c;
      real th, cr;
      iv = $signed(i_in);
      qv = $signed(q_in);
      th = ph * PI / 8.0;
      cr = GAIN * (iv * $sin(th) + qv * $cos(th));
      c  = int'(cr);
      case (mode)
         2'b00: begin
            uses_c = 1'b1; tag = "R3 composite";
            if (sync[1])      raw = c;
            else if (sync[0]) raw = 2 * i_ofs + c;
            else              raw = 2 * y_ofs + y_in + c;
         end
         2'b01: begin
            uses_c = 1'b0; tag = "R4 luma";
            if (sync[1])      raw = 0;
            else if (sync[0]) raw = 2 * i_ofs;
            else              raw = 2 * y_ofs + y_in;
         end
         default: begin
            uses_c = 1'b1; tag = "R5 chroma";
            raw = 2 * q_ofs + c;
         end
      endcase
      tol = uses_c ? 2 : 0;
      if (uses_c) tag = {tag, $sformatf(" R1/R2 phase=%0d", ph)};
      if (iv == 0 && qv == 0) begin
         tol = 0;
         tag = {tag, " R9"};
      end
      if (raw < 0 || raw > 511) tag = {tag, " R6"};
      val = wrap512(raw);
   endfunction

   always @(posedge clk) begin
      #1;
      if (!done) begin
         int    d, v, t, used;
         string tg, lbl;
         if (rst_n && dot_en) begin
            used = start ? 0 : ph_m;
            ph_m = (used + 1) % 16;
            model(used, v, t, tg);
            exp_q.push_back(v);
            tol_q.push_back(t);
            tag_q.push_back(tg);
            if (exp_q.size() > LAT) begin
               cur_exp = exp_q.pop_front();
               cur_tol = tol_q.pop_front();
               cur_tag = tag_q.pop_front();
            end
         end
         lbl = (rst_n && !dot_en) ? {"R7 hold/", cur_tag} : cur_tag;
         compared++;
         d = wrap512(int'(dac_out) - cur_exp);
         if ($isunknown(dac_out) || !(d <= cur_tol || d >= 512 - cur_tol)) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d (tol %0d) at %0t",
                     lbl, dac_out, cur_exp, cur_tol, $time);
         end
      end
   end

   task automatic drive(input bit en, input bit st, input int md, input int sy,
                        input int yv, input int iv, input int qv,
                        input int yo, input int io, input int qo);
      @(negedge clk);
      dot_en = en;      start = st;
      mode   = 2'(md);  sync  = 2'(sy);
      y_in   = 9'(yv);  i_in  = 9'(iv);  q_in = 9'(qv);
      y_ofs  = 8'(yo);  i_ofs = 8'(io);  q_ofs = 8'(qo);
   endtask

   task automatic drive_rand(input bit en, input bit st);
      drive(en, st, int'($urandom % 4), int'($urandom % 4), int'($urandom % 512),
            int'($urandom % 512) - 256, int'($urandom % 512) - 256,
            int'($urandom % 256), int'($urandom % 256), int'($urandom % 256));
   endtask

   initial begin : watchdog
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL R7 watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : stimulus
      #1 rst_n = 1'b0;                                 // R8 reset state
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1: start pins the first sample to phase 0
      drive(1, 1, 0, 0, 100, 50, -30, 20, 40, 64);
      // R2/R3/R4/R5: unbroken dot clock, all modes and sync codes
      for (int n = 0; n < 300; n++) drive_rand(1'b1, 1'b0);
      // R7: gapped dot clock
      for (int n = 0; n < 200; n++) drive_rand(n % 3 == 0, n == 90);
      // R1: restart mid-stream
      drive_rand(1'b1, 1'b1);
      for (int n = 0; n < 40; n++) drive_rand(1'b1, 1'b0);
      // R9: null vector over more than 16 phases, chroma and composite modes
      for (int n = 0; n < 40; n++)
         drive(1, n == 0, (n % 2 == 0) ? 2 : 0, (n % 5 == 0) ? 2 : 0,
               n * 7, 0, 0, n * 3, 30, 100 + n);
      // R6: pedestal and luma large enough to wrap
      drive(1, 0, 1, 0, 511, 0, 0, 255, 0, 0);
      drive(1, 0, 0, 0, 511, 200, 200, 255, 0, 0);
      drive(1, 0, 2, 0, 0, -256, -256, 0, 0, 255);
      drive(1, 0, 0, 1, 0, 255, -256, 0, 255, 0);
      // quarter-turn points with a single axis
      for (int n = 0; n < 16; n++) drive(1, n == 0, 2, 0, 0, 0, 150, 0, 0, 128);
      for (int n = 0; n < 16; n++) drive(1, 0, 2, 0, 0, -120, 0, 0, 0, 128);
      // drain the pipeline
      for (int n = 0; n < LAT + 4; n++) drive(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule